// File: doc/BRIEF.md
# Swap-Cell Master-Slave D Flip-Flop with Two-Vector Test

This block is a D flip-flop made only of three-input controlled-swap cells. Each cell passes its control bit straight through and exchanges its two data bits when the control is 1, so every cell has as many ones at its outputs as at its inputs. A level-sensitive latch that is open while the enable `en` is high acts as the master. A latch that is open while `en` is low acts as the slave, so no inverted enable is needed. Each latch has two cells. The selector cell computes the next state. The copier cell makes two copies of that state, one for the output and one for the feedback tap, so no wire ever fans out.

Each latch has a two-bit mode field `{first, second}`. One code selects normal storage. The other two codes cut the feedback by forcing the tap to a constant. The whole flop can then be tested like combinational logic with only two patterns: every input 0, or every input 1. A monitor compares the number of ones on the twelve cell outputs with the number of ones on the six primary inputs and raises `fault_detected` on a mismatch. The latch state is kept in a register clocked by `clk`, which cuts the feedback loop. `en` acts as the flop's clock level and is sampled at each rising edge of `clk`. The parameters `FAULT_NET` and `FAULT_VAL` tie one chosen cell output to a fixed level, which lets a bench prove that the scheme detects the fault.

Top module: `ms_dff_cswap`

## Requirements
- R1: Every cell maps (c, a, b) to (c, c'·a + c·b, c·a + c'·b). The latch's next state is the middle output of its selector cell.
- R2: In normal mode the master tap `m_tap` follows `d` while `en` is 1. While `en` is 0 it shows the value `d` had at the last rising `clk` edge with `en` at 1.
- R3: In normal mode `q` holds while `en` is 1. While `en` is 0, `q` shows the master's stored value, so `q` changes only after `en` falls.
- R4: Mode code 2'b00 forces the latch's tap to 0 and 2'b11 forces it to 1, in the same cycle. The forced level becomes the stored state and is still present after a return to normal mode.
- R5: With mode code 2'b01 (normal), the tap is an exact copy of the latch output, and a closed latch keeps its tap unchanged from cycle to cycle.
- R6: `fault_detected` is 1 only when all of the following hold. The six inputs (`d`, `en`, both mode bits of both latches) all share one value v. They also had that value at the previous rising `clk` edge. The count of ones on the twelve cell outputs differs from 12·v.
- R7: With no injected fault, `fault_detected` stays 0. With or without a fault, it is 0 whenever the six inputs are not all equal.
- R8: `FAULT_NET` (0 to 11; -1 for none) selects one cell output to tie to `FAULT_VAL`. Nets are counted in this order: master before slave, selector before copier, then outputs pass, first, second. A net tied to 1 is flagged by the all-zeros vector, and a net tied to 0 is flagged by the all-ones vector.
- R9: A synchronous active-high `rst` clears both stored taps and the vector history, so after reset with `en` at 0 and normal mode, `q`, `m_tap`, `s_tap` and `fault_detected` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the state registers |
| rst | input | 1 | Synchronous reset, active high |
| d | input | 1 | Data input |
| en | input | 1 | Flop enable level (master open at 1, slave open at 0) |
| m_mode | input | 2 | Master mode {first, second}: 01 normal, 00 force 0, 11 force 1 |
| s_mode | input | 2 | Slave mode, same encoding |
| q | output | 1 | Flop output |
| m_tap | output | 1 | Master feedback tap |
| s_tap | output | 1 | Slave feedback tap |
| fault_detected | output | 1 | Ones-count mismatch during a held test vector |

## Verification
The hardest condition to reach is a held test vector whose settled cell outputs reveal a single stuck net. A fault-free design shows no mismatch on any vector. The bench therefore instantiates 24 copies, one for each net tied to each level, next to a fault-free copy. It drives them all with the same stimulus. First it loads state 1, which makes the first cycle of the zeros vector out of balance. Then it holds each vector for two edges. It records which copies flag under zeros and which under ones, so the settle gate and the detection rule are both exercised.

// File: rtl/cswap_pkg.sv
package cswap_pkg;

    localparam int CELL_OUTS      = 3;
    localparam int CELLS_PER_LAT  = 2;
    localparam int NETS_PER_LAT   = CELL_OUTS * CELLS_PER_LAT;
    localparam int NUM_LATCHES    = 2;
    localparam int NUM_NETS       = NETS_PER_LAT * NUM_LATCHES;
    localparam int NUM_PRIM       = 6;

    typedef enum logic [1:0] {
        MODE_ZERO = 2'b00,
        MODE_NORM = 2'b01,
        MODE_ONE  = 2'b11
    } mode_e;

    typedef struct packed {
        logic o2;
        logic o1;
        logic o0;
    } cell_out_t;

    function automatic cell_out_t cswap(input logic c, input logic a, input logic b);
        cell_out_t r;
        r.o0 = c;
        r.o1 = (~c & a) | (c & b);
        r.o2 = (c & a) | (~c & b);
        return r;
    endfunction

endpackage

// File: rtl/cswap_cell.sv
module cswap_cell
    import cswap_pkg::*;
#(
    parameter bit FLT_EN  = 1'b0,
    parameter int FLT_BIT = 0,
    parameter bit FLT_VAL = 1'b0
) (
    input  logic      c,
    input  logic      a,
    input  logic      b,
    output cell_out_t y
);

    cell_out_t ideal;
    assign ideal = cswap(c, a, b);

    generate
        if (FLT_EN) begin : g_stuck
            always_comb begin
                y = ideal;
                case (FLT_BIT)
                    0:       y.o0 = FLT_VAL;
                    1:       y.o1 = FLT_VAL;
                    default: y.o2 = FLT_VAL;
                endcase
            end
        end else begin : g_clean
            assign y = ideal;
        end
    endgenerate

endmodule

// File: rtl/mode_latch.sv
module mode_latch
    import cswap_pkg::*;
#(
    parameter bit OPEN_HIGH = 1'b1,
    parameter int FLT_NET   = -1,
    parameter bit FLT_VAL   = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    d,
    input  mode_e                   mode,
    output logic                    q,
    output logic                    tap,
    output logic [NETS_PER_LAT-1:0] nets
);

    localparam logic OPEN_LVL = OPEN_HIGH;
    localparam bit   SEL_FLT  = (FLT_NET >= 0) && (FLT_NET < CELL_OUTS);
    localparam bit   CPY_FLT  = (FLT_NET >= CELL_OUTS) && (FLT_NET < NETS_PER_LAT);

    logic      tap_q;
    logic      sel_a;
    logic      sel_b;
    cell_out_t sel_y;
    cell_out_t cpy_y;

    generate
        if (OPEN_HIGH) begin : g_pos
            assign sel_a = tap_q;
            assign sel_b = d;
        end else begin : g_neg
            assign sel_a = d;
            assign sel_b = tap_q;
        end
    endgenerate

    cswap_cell #(
        .FLT_EN (SEL_FLT),
        .FLT_BIT(FLT_NET % CELL_OUTS),
        .FLT_VAL(FLT_VAL)
    ) u_sel (
        .c(en),
        .a(sel_a),
        .b(sel_b),
        .y(sel_y)
    );

    cswap_cell #(
        .FLT_EN (CPY_FLT),
        .FLT_BIT(FLT_NET % CELL_OUTS),
        .FLT_VAL(FLT_VAL)
    ) u_copy (
        .c(sel_y.o1),
        .a(mode[1]),
        .b(mode[0]),
        .y(cpy_y)
    );

    assign q    = cpy_y.o0;
    assign tap  = cpy_y.o1;
    assign nets = {cpy_y, sel_y};

    always_ff @(posedge clk) begin
        if (rst) tap_q <= 1'b0;
        else     tap_q <= tap;
    end

    generate
        if (FLT_NET < 0) begin : g_chk
            // R4
            zero_force_chk: assert property (@(posedge clk) disable iff (rst)
                (mode == MODE_ZERO) |-> (tap == 1'b0));
            // R4
            one_force_chk: assert property (@(posedge clk) disable iff (rst)
                (mode == MODE_ONE) |-> (tap == 1'b1));
            // R2
            open_pass_chk: assert property (@(posedge clk) disable iff (rst)
                (mode == MODE_NORM && en == OPEN_LVL) |-> (q == d));
            // R5
            closed_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(mode == MODE_NORM) && mode == MODE_NORM && en != OPEN_LVL)
                |-> (tap == $past(tap)));
        end
    endgenerate

endmodule

// File: rtl/fault_monitor.sv
module fault_monitor
    import cswap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PRIM-1:0] prim,
    input  logic [NUM_NETS-1:0] nets,
    output logic                flag
);

    logic all0;
    logic all1;
    logic prev0;
    logic prev1;
    logic settled;
    int   ones;

    assign all0    = (prim == '0);
    assign all1    = (&prim);
    assign settled = (all0 && prev0) || (all1 && prev1);
    assign ones    = $countones(nets);
    assign flag    = settled && (ones != (all1 ? NUM_NETS : 0));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev0 <= 1'b0;
            prev1 <= 1'b0;
        end else begin
            prev0 <= all0;
            prev1 <= all1;
        end
    end

endmodule

// File: rtl/ms_dff_cswap.sv
module ms_dff_cswap
    import cswap_pkg::*;
#(
    parameter int FAULT_NET = -1,
    parameter bit FAULT_VAL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       d,
    input  logic       en,
    input  logic [1:0] m_mode,
    input  logic [1:0] s_mode,
    output logic       q,
    output logic       m_tap,
    output logic       s_tap,
    output logic       fault_detected
);

    localparam int M_FLT = (FAULT_NET >= 0 && FAULT_NET < NETS_PER_LAT) ? FAULT_NET : -1;
    localparam int S_FLT = (FAULT_NET >= NETS_PER_LAT && FAULT_NET < NUM_NETS)
                           ? FAULT_NET - NETS_PER_LAT : -1;

    logic                    m_q;
    logic [NETS_PER_LAT-1:0] m_nets;
    logic [NETS_PER_LAT-1:0] s_nets;

    mode_latch #(.OPEN_HIGH(1'b1), .FLT_NET(M_FLT), .FLT_VAL(FAULT_VAL)) u_master (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (d),
        .mode(mode_e'(m_mode)),
        .q   (m_q),
        .tap (m_tap),
        .nets(m_nets)
    );

    mode_latch #(.OPEN_HIGH(1'b0), .FLT_NET(S_FLT), .FLT_VAL(FAULT_VAL)) u_slave (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .d   (m_q),
        .mode(mode_e'(s_mode)),
        .q   (q),
        .tap (s_tap),
        .nets(s_nets)
    );

    fault_monitor u_mon (
        .clk (clk),
        .rst (rst),
        .prim({d, en, m_mode, s_mode}),
        .nets({s_nets, m_nets}),
        .flag(fault_detected)
    );

    generate
        if (FAULT_NET < 0) begin : g_chk
            // R7
            no_false_flag_chk: assert property (@(posedge clk) disable iff (rst)
                !fault_detected);
            // R3
            slave_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && en && $past(en) && m_mode == 2'b01 && s_mode == 2'b01
                 && $past(m_mode == 2'b01 && s_mode == 2'b01)) |-> $stable(q));
        end
    endgenerate

endmodule

// File: tb/ms_dff_cswap_tb_top.sv
module ms_dff_cswap_tb_top;

    localparam int NF    = 24;
    localparam int STEPS = 12;
    // each entry: {d, en, expected q, expected m_tap}
    localparam logic [3:0] TBL [STEPS] = '{
        4'b1101, 4'b0100, 4'b1101, 4'b0011,
        4'b0011, 4'b0110, 4'b1000, 4'b1000,
        4'b1101, 4'b1011, 4'b0110, 4'b0000
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       d = 1'b0;
    logic       en = 1'b0;
    logic [1:0] m_mode = 2'b01;
    logic [1:0] s_mode = 2'b01;
    logic       q, m_tap, s_tap, flag;
    logic [NF-1:0] f_flag, f_q, f_mt, f_st;
    logic [NF-1:0] zero_seen, one_seen;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ms_dff_cswap dut_i (
        .clk(clk), .rst(rst), .d(d), .en(en), .m_mode(m_mode), .s_mode(s_mode),
        .q(q), .m_tap(m_tap), .s_tap(s_tap), .fault_detected(flag)
    );

    generate
        for (genvar n = 0; n < 12; n++) begin : g_net
            for (genvar v = 0; v < 2; v++) begin : g_val
                ms_dff_cswap #(.FAULT_NET(n), .FAULT_VAL(v == 1)) u_f (
                    .clk(clk), .rst(rst), .d(d), .en(en), .m_mode(m_mode), .s_mode(s_mode),
                    .q(f_q[n*2+v]), .m_tap(f_mt[n*2+v]), .s_tap(f_st[n*2+v]),
                    .fault_detected(f_flag[n*2+v])
                );
            end
        end
    endgenerate

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic dv, input logic ev, input logic [1:0] mm, input logic [1:0] sm);
        @(negedge clk);
        d = dv; en = ev; m_mode = mm; s_mode = sm;
        #5;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        chk("R9 reset q", q, 1'b0);
        chk("R9 reset m_tap", m_tap, 1'b0);
        chk("R9 reset s_tap", s_tap, 1'b0);
        chk("R9 reset flag", flag, 1'b0);

        for (int i = 0; i < STEPS; i++) begin
            drive(TBL[i][3], TBL[i][2], 2'b01, 2'b01);
            chk("R3 table q", q, TBL[i][1]);
            chk("R1 R2 table m_tap", m_tap, TBL[i][0]);
            chk("R5 table s_tap copy", s_tap, q);
            chk("R7 table flag", flag, 1'b0);
        end

        // load state 1 in both latches
        drive(1'b1, 1'b1, 2'b01, 2'b01);
        drive(1'b0, 1'b0, 2'b01, 2'b01);
        drive(1'b0, 1'b0, 2'b01, 2'b01);
        chk("R3 loaded q", q, 1'b1);

        // all-zeros vector
        drive(1'b0, 1'b0, 2'b00, 2'b00);
        chk("R4 zeros m_tap forced", m_tap, 1'b0);
        chk("R6 zeros first cycle no flag", flag, 1'b0);
        chk("R8 zeros first cycle no flag on faults", |f_flag, 1'b0);
        drive(1'b0, 1'b0, 2'b00, 2'b00);
        chk("R4 zeros q settled", q, 1'b0);
        chk("R4 zeros s_tap", s_tap, 1'b0);
        chk("R6 zeros fault-free flag", flag, 1'b0);
        zero_seen = f_flag;

        // all-ones vector
        drive(1'b1, 1'b1, 2'b11, 2'b11);
        chk("R4 ones m_tap forced", m_tap, 1'b1);
        chk("R4 ones s_tap forced", s_tap, 1'b1);
        drive(1'b1, 1'b1, 2'b11, 2'b11);
        chk("R4 ones q settled", q, 1'b1);
        chk("R6 ones fault-free flag", flag, 1'b0);
        one_seen = f_flag;

        for (int i = 0; i < NF; i++) begin
            chk($sformatf("R8 net %0d val %0d zeros", i / 2, i % 2), zero_seen[i], (i % 2) == 1);
            chk($sformatf("R8 net %0d val %0d ones", i / 2, i % 2), one_seen[i], (i % 2) == 0);
        end

        // mixed vector: no flag anywhere
        drive(1'b0, 1'b0, 2'b11, 2'b01);
        drive(1'b0, 1'b0, 2'b11, 2'b01);
        chk("R7 mixed vector fault copies", |f_flag, 1'b0);
        chk("R7 mixed vector flag", flag, 1'b0);

        // forced level kept after return to normal
        drive(1'b0, 1'b0, 2'b01, 2'b01);
        chk("R4 forced state kept q", q, 1'b1);
        chk("R4 forced state kept m_tap", m_tap, 1'b1);

        // reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #5;
        chk("R9 mid reset q", q, 1'b0);
        chk("R9 mid reset m_tap", m_tap, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule